// File: doc/BRIEF.md
# Packed I/Q Phase Extraction Pipeline

This block turns a stream of packed in-phase/quadrature samples into a stream of packed 8-bit phase angles. Each 32-bit input word carries two signed 8-bit I/Q pairs. The block splits each word into its two pairs and feeds them, one pair per clock, into a fully pipelined vectoring CORDIC. The CORDIC uses only shifts and additions to compute a four-quadrant arctangent. The resulting 8-bit phases are gathered four at a time into 32-bit output words.

A run begins with a single-cycle `start` pulse that carries the number of samples to process. The block then accepts exactly as many input words as that count needs and emits exactly as many output words as the results fill. It raises `done` once the last output word has been taken. Both word streams use a valid/ready handshake. A stall on the output side freezes the whole pipeline, so no sample is lost or repeated. Once the pipeline is full it takes one new pair every clock, so a run of N samples costs a fixed latency plus N cycles.

Top module: `iqpk_top`

## Requirements
- R1: In an input word, bits 7:0 hold I of the first pair, bits 15:8 hold Q of the first pair, bits 23:16 hold I of the second pair and bits 31:24 hold Q of the second pair. The first pair is processed before the second.
- R2: Bits 8k+7:8k of an output word hold the phase of sample k (k = 0..3) of its group of four, and groups leave in arrival order.
- R3: The phase is a two's-complement byte on which 128 counts equal π, covering all four quadrants (±π reads as -128). It lies within 1 count of the exact atan2(Q, I).
- R4: A sample with I = 0 and Q = 0 yields a phase of exactly 0.
- R5: When the sample count is not a multiple of four, the unused upper bytes of the final output word are zero.
- R6: After reset, `done` is low. `done` rises in the cycle after the final output word is accepted, and stays high until the next accepted start. A start with a count of zero raises `done` one cycle later and moves no words.
- R7: A run accepts exactly ceil(count/2) input words, and `in_ready` stays low outside a run and after the last word. For an odd count, the second pair of the last word is discarded.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds still. No result is lost or duplicated under back-pressure.
- R9: With input always offered and output always ready, the cycles from start to `done` grow by exactly one per extra sample.
- R10: A start pulse during an active run is ignored. The run finishes with its original count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| sample_count | input | CNT_W | Number of samples in the run, read at start |
| done | output | 1 | Run complete, held until the next start |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken this cycle if valid |
| in_data | input | 32 | Two packed I/Q pairs |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Four packed phase bytes |

## Verification
The properties assume that `start` is pulsed only when no run is active, or that any pulse during a run is harmless. They also assume the producer holds each offered word until `in_ready` accepts it, and that `sample_count` is meaningful only on the start cycle. The stimulus changes inputs only between clock edges. It drives a word for exactly as long as the block still needs words, and it pulses start mid-run in only one deliberate case. Random valid and ready gaps, extreme sample values (-128, 127, axis points, zero vectors), and counts of every residue modulo four are applied, so the padding and odd-count rules are all exercised.

// File: rtl/iqpk_pkg.sv
package iqpk_pkg;
    localparam int IQ_W      = 8;
    localparam int FRAC_W    = 7;
    localparam int XW        = IQ_W + 2 + FRAC_W;
    localparam int PH_W      = 8;
    localparam int ANG_W     = 16;
    localparam int LANES     = 4;
    localparam int PAIRS     = 2;
    localparam int IN_W      = 2 * PAIRS * IQ_W;
    localparam int OUT_W     = LANES * PH_W;
    localparam int MAX_ITERS = 16;

    typedef struct packed {
        logic signed [IQ_W-1:0] i;
        logic signed [IQ_W-1:0] q;
    } pair_t;

    typedef struct packed {
        logic                    vld;
        logic                    zero;
        logic signed [XW-1:0]    x;
        logic signed [XW-1:0]    y;
        logic signed [ANG_W-1:0] z;
    } vec_t;

    // atan(2^-k) on a scale where a full turn is 2^16
    function automatic logic [ANG_W-1:0] atan_step(int k);
        case (k)
            0:  return 16'd8192;
            1:  return 16'd4836;
            2:  return 16'd2555;
            3:  return 16'd1297;
            4:  return 16'd651;
            5:  return 16'd326;
            6:  return 16'd163;
            7:  return 16'd81;
            8:  return 16'd41;
            9:  return 16'd20;
            10: return 16'd10;
            11: return 16'd5;
            12: return 16'd3;
            13: return 16'd1;
            14: return 16'd1;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [PH_W-1:0] angle_to_phase(logic [ANG_W-1:0] z);
        return PH_W'((z + ANG_W'(1 << (ANG_W - PH_W - 1))) >> (ANG_W - PH_W));
    endfunction
endpackage

// File: rtl/iqpk_unpack.sv
module iqpk_unpack
    import iqpk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] count,
    input  logic             adv,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    output logic             pair_vld,
    output pair_t            pair
);
    logic [CNT_W-1:0] words_left, pairs_left;
    logic             held, half;
    logic [IN_W-1:0]  word;
    logic             issue, drain, accept;

    always_comb begin
        issue    = held && adv;
        drain    = issue && (half || (pairs_left == CNT_W'(1)));
        in_ready = (words_left != '0) && (!held || drain);
        accept   = in_valid && in_ready;
        pair_vld = issue;
        pair.i   = half ? word[2*IQ_W +: IQ_W] : word[0 +: IQ_W];
        pair.q   = half ? word[3*IQ_W +: IQ_W] : word[IQ_W +: IQ_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_left <= '0;
            pairs_left <= '0;
            held       <= 1'b0;
            half       <= 1'b0;
            word       <= '0;
        end else if (launch) begin
            words_left <= CNT_W'(({1'b0, count} + (CNT_W+1)'(1)) >> 1);
            pairs_left <= count;
            held       <= 1'b0;
            half       <= 1'b0;
        end else begin
            if (issue) begin
                pairs_left <= pairs_left - CNT_W'(1);
                half       <= ~half;
                if (drain) held <= 1'b0;
            end
            if (accept) begin
                word       <= in_data;
                held       <= 1'b1;
                half       <= 1'b0;
                words_left <= words_left - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/iqpk_cordic_stage.sv
module iqpk_cordic_stage
    import iqpk_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  vec_t d,
    output vec_t q
);
    localparam logic [ANG_W-1:0] STEP = atan_step(SHIFT);

    logic signed [XW-1:0] xi, yi, xs, ys;
    vec_t nxt;

    always_comb begin
        xi  = d.x;
        yi  = d.y;
        xs  = xi >>> SHIFT;
        ys  = yi >>> SHIFT;
        nxt = d;
        if (!yi[XW-1]) begin
            nxt.x = xi + ys;
            nxt.y = yi - xs;
            nxt.z = d.z + STEP;
        end else begin
            nxt.x = xi - ys;
            nxt.y = yi + xs;
            nxt.z = d.z - STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= nxt;
    end
endmodule

// File: rtl/iqpk_cordic.sv
module iqpk_cordic
    import iqpk_pkg::*;
#(
    parameter int ITERS = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            in_vld,
    input  pair_t           in_pair,
    output logic            out_vld,
    output logic [PH_W-1:0] out_phase
);
    localparam logic signed [ANG_W-1:0] QUARTER = ANG_W'(1 << (ANG_W - 2));
    localparam int PAD = XW - IQ_W - FRAC_W;

    vec_t chain [0:ITERS];
    vec_t pre;
    logic signed [XW-1:0] xe, ye;

    // fold the vector into the right half-plane
    always_comb begin
        xe       = {{PAD{in_pair.i[IQ_W-1]}}, in_pair.i, {FRAC_W{1'b0}}};
        ye       = {{PAD{in_pair.q[IQ_W-1]}}, in_pair.q, {FRAC_W{1'b0}}};
        pre.vld  = in_vld;
        pre.zero = (in_pair.i == '0) && (in_pair.q == '0);
        if (in_pair.i[IQ_W-1]) begin
            if (!in_pair.q[IQ_W-1]) begin
                pre.x = ye;
                pre.y = -xe;
                pre.z = QUARTER;
            end else begin
                pre.x = -ye;
                pre.y = xe;
                pre.z = -QUARTER;
            end
        end else begin
            pre.x = xe;
            pre.y = ye;
            pre.z = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     chain[0] <= '0;
        else if (en) chain[0] <= pre;
    end

    for (genvar k = 0; k < ITERS; k++) begin : g_stage
        iqpk_cordic_stage #(.SHIFT(k)) u_stage (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .d   (chain[k]),
            .q   (chain[k+1])
        );
    end

    always_comb begin
        out_vld   = chain[ITERS].vld;
        out_phase = chain[ITERS].zero ? '0 : angle_to_phase(chain[ITERS].z);
    end
endmodule

// File: rtl/iqpk_repack.sv
module iqpk_repack
    import iqpk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             ph_vld,
    input  logic [PH_W-1:0]  ph,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             done,
    output logic             active,
    output logic             adv,
    output logic             launch
);
    localparam int LW = $clog2(LANES);

    logic             active_q, done_q, last_q, ov;
    logic [CNT_W-1:0] left;
    logic [LW-1:0]    lane;
    logic [OUT_W-1:0] acc, od, merged;
    logic             take, flush;

    always_comb begin
        adv    = !(ov && !out_ready);
        launch = start && !active_q;
        take   = ph_vld && adv;
        flush  = (lane == LW'(LANES - 1)) || (left == CNT_W'(1));
        merged = acc;
        merged[lane*PH_W +: PH_W] = ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            last_q   <= 1'b0;
            ov       <= 1'b0;
            left     <= '0;
            lane     <= '0;
            acc      <= '0;
            od       <= '0;
        end else begin
            if (ov && out_ready) begin
                ov <= 1'b0;
                if (last_q) begin
                    done_q   <= 1'b1;
                    active_q <= 1'b0;
                    last_q   <= 1'b0;
                end
            end
            if (take) begin
                left <= left - CNT_W'(1);
                if (flush) begin
                    ov     <= 1'b1;
                    od     <= merged;
                    acc    <= '0;
                    lane   <= '0;
                    last_q <= (left == CNT_W'(1));
                end else begin
                    acc  <= merged;
                    lane <= lane + LW'(1);
                end
            end
            if (launch) begin
                active_q <= (count != '0);
                done_q   <= (count == '0);
                left     <= count;
                lane     <= '0;
                acc      <= '0;
                last_q   <= 1'b0;
            end
        end
    end

    assign out_valid = ov;
    assign out_data  = od;
    assign done      = done_q;
    assign active    = active_q;
endmodule

// File: rtl/iqpk_top.sv
module iqpk_top
    import iqpk_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ITERS = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] sample_count,
    output logic             done,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    logic            adv, launch, run_active;
    logic            pair_vld, ph_vld;
    pair_t           pair;
    logic [PH_W-1:0] ph;

    iqpk_unpack #(.CNT_W(CNT_W)) u_unpack (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .count    (sample_count),
        .adv      (adv),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .pair_vld (pair_vld),
        .pair     (pair)
    );

    iqpk_cordic #(.ITERS(ITERS)) u_cordic (
        .clk       (clk),
        .rst       (rst),
        .en        (adv),
        .in_vld    (pair_vld),
        .in_pair   (pair),
        .out_vld   (ph_vld),
        .out_phase (ph)
    );

    iqpk_repack #(.CNT_W(CNT_W)) u_repack (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .count     (sample_count),
        .ph_vld    (ph_vld),
        .ph        (ph),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .done      (done),
        .active    (run_active),
        .adv       (adv),
        .launch    (launch)
    );
endmodule

// File: rtl/iqpk_checker.sv
module iqpk_checker
    import iqpk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] sample_count,
    input logic             run_active,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             done
);
    logic [CNT_W-1:0] cnt_q, wout, win;
    logic [CNT_W:0]   n_out, n_in;
    logic             is_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            wout  <= '0;
            win   <= '0;
        end else if (start && !run_active) begin
            cnt_q <= sample_count;
            wout  <= '0;
            win   <= '0;
        end else begin
            if (out_valid && out_ready) wout <= wout + CNT_W'(1);
            if (in_valid && in_ready)   win  <= win + CNT_W'(1);
        end
    end

    always_comb begin
        n_out   = ({1'b0, cnt_q} + (CNT_W+1)'(3)) >> 2;
        n_in    = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >> 1;
        is_last = (({1'b0, wout} + (CNT_W+1)'(1)) == n_out);
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(out_valid && out_ready) || $past(start && sample_count == '0));

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    p_idle_no_ready_r7: assert property (@(posedge clk) disable iff (rst)
        !run_active |-> !in_ready);

    p_word_budget_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> ({1'b0, win} < n_in));

    p_zero_pad_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && is_last && (cnt_q[1:0] != 2'b00)
        |-> ((out_data >> (PH_W * cnt_q[1:0])) == '0));
endmodule

bind iqpk_top iqpk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .sample_count (sample_count),
    .run_active   (run_active),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .done         (done)
);

// File: tb/iqpk_top_test.sv
module iqpk_top_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] sample_count = '0;
    logic             done;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [31:0]      out_data;

    logic signed [7:0] si [0:255];
    logic signed [7:0] sq [0:255];

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    iqpk_top #(.CNT_W(CNT_W), .ITERS(11)) uut (
        .clk(clk), .rst(rst), .start(start), .sample_count(sample_count),
        .done(done), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] word_of(int w);
        return {sq[2*w+1], si[2*w+1], sq[2*w], si[2*w]};
    endfunction

    function automatic real ref_phase(int k);
        return $atan2(real'(sq[k]), real'(si[k])) * 128.0 / 3.14159265358979;
    endfunction

    task automatic check(bit ok, string req, string what, int got, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_byte(string tag, int k, logic [7:0] got, int n);
        int g = $signed(got);
        n_cmp++;
        if (k >= n) begin
            if (got != 8'h00) begin
                n_bad++;
                $display("FAIL R5 %s pad byte %0d: got %0d expected 0", tag, k, g);
            end
        end else if (si[k] == 0 && sq[k] == 0) begin
            if (got != 8'h00) begin
                n_bad++;
                $display("FAIL R4 %s sample %0d: got %0d expected 0", tag, k, g);
            end
        end else begin
            real e = ref_phase(k);
            real d = real'(g) - e;
            while (d >= 128.0) d -= 256.0;
            while (d < -128.0) d += 256.0;
            if (d > 1.0 || d < -1.0) begin
                n_bad++;
                $display("FAIL R2 R3 %s sample %0d (I=%0d Q=%0d): got %0d expected %0.2f",
                         tag, k, si[k], sq[k], g, e);
            end
        end
    endtask

    task automatic fill_random();
        for (int k = 0; k < 256; k++) begin
            int sel = $urandom % 16;
            si[k] = 8'($urandom);
            sq[k] = 8'($urandom);
            if (sel == 0) begin si[k] = 0; sq[k] = 0; end
            if (sel == 1) si[k] = -128;
            if (sel == 2) sq[k] = 127;
            if (sel == 3) begin si[k] = -128; sq[k] = -128; end
        end
    endtask

    task automatic run_case(string tag, int n, int pin, int pout, bit poke, output int dur);
        int words = (n + 1) / 2;
        int nout  = (n + 3) / 4;
        int wi = 0;
        int wo = 0;
        int t  = 1;
        bit prev_stall = 1'b0;
        logic [31:0] prev_data = '0;
        @(negedge clk);
        start = 1'b1;
        sample_count = CNT_W'(n);
        in_valid = 1'b0;
        @(negedge clk);
        forever begin
            start = (poke && t == 6);
            if (poke && t == 6) sample_count = CNT_W'(3);
            in_valid = (wi < words) && (($urandom % 100) < pin);
            in_data  = in_valid ? word_of(wi) : 32'($urandom);
            out_ready = (($urandom % 100) < pout);
            #1;
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R8", {tag, " held word"},
                      int'(out_data), int'(prev_data));
            if (done) break;
            if (in_valid && in_ready) wi++;
            if (out_valid && out_ready) begin
                for (int k = 0; k < 4; k++)
                    check_byte(tag, 4*wo + k, out_data[8*k +: 8], n);
                wo++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            @(negedge clk);
            t++;
            if (t > 5000) begin
                check(1'b0, "R6", {tag, " run never finished"}, t, 0);
                break;
            end
        end
        start = 1'b0;
        in_valid = 1'b0;
        check(wi == words, "R7", {tag, " input words taken"}, wi, words);
        check(wo == nout, "R2", {tag, " output words"}, wo, nout);
        check(!in_ready, "R7", {tag, " in_ready after done"}, int'(in_ready), 0);
        if (poke) check(wo == nout, "R10", {tag, " mid-run start ignored"}, wo, nout);
        dur = t;
    endtask

    initial begin
        int d1, d2, dx;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !out_valid && !in_ready, "R6", "reset state",
              int'({done, out_valid, in_ready}), 0);

        // R1: byte layout with distinct quadrant points
        fill_random();
        si[0] = 100;  sq[0] = 0;
        si[1] = 0;    sq[1] = 100;
        si[2] = -100; sq[2] = 0;
        si[3] = 0;    sq[3] = -100;
        run_case("R1 layout", 4, 100, 100, 1'b0, dx);

        // R4 zero vectors, R5 padding, R7 odd count with junk upper pair
        fill_random();
        si[2] = 0; sq[2] = 0;
        si[5] = 0; sq[5] = 0;
        si[7] = 77; sq[7] = -33;
        run_case("R4 R5 odd", 7, 70, 60, 1'b0, dx);

        // R6: zero count
        @(negedge clk);
        start = 1'b1;
        sample_count = '0;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(done && !out_valid && !in_ready, "R6", "zero-count run",
              int'({done, out_valid, in_ready}), 4);

        // R9: throughput with no gaps
        fill_random();
        run_case("R9 short", 8, 100, 100, 1'b0, d1);
        fill_random();
        run_case("R9 long", 40, 100, 100, 1'b0, d2);
        check(d2 - d1 == 32, "R9", "extra cycles for 32 extra samples", d2 - d1, 32);

        // R10: start pulse during a run
        fill_random();
        run_case("R10 poke", 21, 80, 70, 1'b1, dx);

        // R8: heavy back-pressure
        fill_random();
        run_case("R8 stall", 30, 90, 20, 1'b0, dx);

        // random mix
        for (int r = 0; r < 10; r++) begin
            int n = 1 + ($urandom % 60);
            fill_random();
            run_case("random", n, 40 + ($urandom % 61), 30 + ($urandom % 71), 1'b0, dx);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 180000);
        n_cmp++;
        n_bad++;
        $display("FAIL R6 watchdog expired: got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule